// File: doc/BRIEF.md
# Chained-Transfer SPI Master

This block is an SPI bus master driven by two write strobes. A config write latches one word: eight mode flags, a transfer length, a clock divisor and a slave-select mask. A data write loads the shift register and starts one transfer. Chip select is raised at the start of the first transfer. It stays active through any number of following transfers, and it is released only when a transfer completes whose config carried the end flag. A multi-part exchange, such as an 8-bit opcode followed by a 32-bit payload, therefore appears on the bus as one selection window. Each transfer may use its own length, divisor, mask and bit order.

When the capture flag is set, the bits shifted in during a transfer are presented as a one-cycle read event at its end. A half-duplex mode turns the MOSI line into the data input, so that three-wire slaves can be read. An offline flag releases every pin. Writes that arrive while a transfer runs are refused and flagged with an error pulse.

Top module: `spi_xfer_master`

## Requirements
- R1: Config word layout: bit 0 offline, bit 1 end-of-transaction, bit 2 capture, bit 3 chip-select active level, bit 4 SCK idle level, bit 5 phase, bit 6 LSB-first, bit 7 half-duplex, bits 12:8 length minus one (1 to 32 bits), bits 20:13 divisor minus two, and bits from 21 upward the chip-select mask (one bit per slave). A config write taken while idle applies to the next transfer.
- R2: A data write while idle raises busy_o at the next clock edge. With divisor d = field + 2 (2 to 257), each bit spends floor(d/2) clocks in its first half and ceil(d/2) clocks in its second half, so busy_o stays high for exactly length × d cycles.
- R3: In MSB-first mode bits leave from bit 31 of the data word downward, so shorter payloads are left-aligned. In LSB-first mode they leave from bit 0 upward. Received bits are right-aligned: in MSB-first mode the last bit lands in bit 0, and in LSB-first mode the first bit lands in bit 0.
- R4: When idle, SCK rests at the idle-level flag. With phase clear, input is sampled on the leading edge and output changes on the trailing edge; with phase set, this is reversed.
- R5: A selected slave's chip select is driven to the active-level flag from the start of a transfer. It stays active across transfers until one with the end flag completes, and then every chip select returns to the inactive level.
- R6: With the capture flag set, rd_valid_o pulses for one cycle in the cycle busy_o falls, and rd_data_o then holds the received word. With the flag clear, no pulse is produced.
- R7: In half-duplex mode input is taken from mosi_i instead of miso_i. When capture is also set, mosi_oe_o is low so the slave can drive the line.
- R8: With the offline flag set, pins_oe_o and mosi_oe_o are low.
- R9: A config or data write while busy_o is high is ignored (the running transfer keeps its length and bits) and produces err_o high in the following cycle.
- R10: A config write and a data write in the same cycle while idle start a transfer that uses the newly written config.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_i | input | 21+NCS | Config word |
| data_we_i | input | 1 | Data write strobe, starts a transfer |
| data_i | input | 32 | Transmit word |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Write refused during a transfer |
| rd_valid_o | output | 1 | Read event strobe |
| rd_data_o | output | 32 | Received word |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable of MOSI |
| mosi_i | input | 1 | MOSI line read back, for half-duplex input |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCS | Chip selects |
| pins_oe_o | output | 1 | Output enable of SCK and chip selects |

## Verification
Two things can land on the same edge. A config write and a data write in the same idle cycle must start a transfer under the new config. A transfer's completion must coincide with its read event, with chip-select release and with busy falling. The bench issues both strobes together with a length and phase different from the config in force, then checks the duration and the shifted bits against the new values. For completion, the read-event pulse is compared against the cycle in which busy drops, and the chip-select levels are checked immediately afterwards.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int DW     = 32;
  localparam int LENW   = 5;
  localparam int DIVW   = 8;
  localparam int LEN_LO = 8;
  localparam int DIV_LO = LEN_LO + LENW;
  localparam int CS_LO  = DIV_LO + DIVW;

  typedef struct packed {
    logic half;
    logic lsb;
    logic cpha;
    logic cpol;
    logic cs_pol;
    logic cap;
    logic last;
    logic offline;
  } flags_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            run_i,
  input  logic [DIVW-1:0] div_m2_i,
  output logic            half_end_o,
  output logic            odd_o
);
  localparam int CW = DIVW + 1;

  logic [CW-1:0] cnt_q, div_full, len_lo, len_hi;
  logic          odd_q;

  assign div_full   = {1'b0, div_m2_i} + CW'(2);
  assign len_lo     = div_full >> 1;
  assign len_hi     = div_full - len_lo;
  assign half_end_o = run_i && (cnt_q == CW'(1));
  assign odd_o      = odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= len_lo;
      odd_q <= 1'b0;
    end else if (half_end_o) begin
      odd_q <= ~odd_q;
      cnt_q <= odd_q ? len_lo : len_hi;
    end else if (run_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] tx_i,
  input  logic          lsb_i,
  input  logic          sample_i,
  input  logic          shift_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic [DW-1:0] rx_o
);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] tx_q, rx_q;
  logic [IW-1:0] idx_q;

  assign dout_o = lsb_i ? tx_q[0] : tx_q[DW-1];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      tx_q  <= tx_i;
      rx_q  <= '0;
      idx_q <= '0;
    end else begin
      if (shift_i) tx_q <= lsb_i ? (tx_q >> 1) : (tx_q << 1);
      if (sample_i) begin
        if (lsb_i) rx_q[idx_q] <= din_i;
        else       rx_q <= {rx_q[DW-2:0], din_i};
        idx_q <= idx_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CS_LO+NCS-1:0] cfg_i,
  input  logic              data_we_i,
  input  logic [DW-1:0]     data_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic [NCS-1:0]    cs_o,
  output logic              pins_oe_o
);
  localparam int HW = LENW + 1;

  flags_t          flags_q;
  logic [LENW-1:0] len_q;
  logic [DIVW-1:0] div_q, div_sel;
  logic [NCS-1:0]  mask_q;
  logic            busy_q, cs_act_q, rdv_q, err_q;
  logic [HW-1:0]   half_q;
  logic            start, take_cfg, half_end, odd, last_half, din;

  assign take_cfg  = cfg_we_i && !busy_q;
  assign start     = data_we_i && !busy_q;
  assign last_half = (half_q == {len_q, 1'b1});
  assign div_sel   = take_cfg ? cfg_i[DIV_LO +: DIVW] : div_q;
  assign din       = flags_q.half ? mosi_i : miso_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      len_q   <= '0;
      div_q   <= '0;
      mask_q  <= '0;
    end else if (take_cfg) begin
      flags_q <= flags_t'(cfg_i[7:0]);
      len_q   <= cfg_i[LEN_LO +: LENW];
      div_q   <= cfg_i[DIV_LO +: DIVW];
      mask_q  <= cfg_i[CS_LO +: NCS];
    end
  end

  spi_clk_div #(.DIVW(DIVW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .run_i      (busy_q),
    .div_m2_i   (div_sel),
    .half_end_o (half_end),
    .odd_o      (odd)
  );

  spi_shift_eng #(.DW(DW)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .tx_i     (data_i),
    .lsb_i    (flags_q.lsb),
    .sample_i (half_end && !odd),
    .shift_i  (half_end && odd && !last_half),
    .din_i    (din),
    .dout_o   (mosi_o),
    .rx_o     (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      half_q   <= '0;
      cs_act_q <= 1'b0;
      rdv_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rdv_q <= busy_q && half_end && last_half && flags_q.cap;
      err_q <= busy_q && (cfg_we_i || data_we_i);
      if (start) begin
        busy_q   <= 1'b1;
        half_q   <= '0;
        cs_act_q <= 1'b1;
      end else if (half_end) begin
        if (last_half) begin
          busy_q <= 1'b0;
          if (flags_q.last) cs_act_q <= 1'b0;
        end else begin
          half_q <= half_q + HW'(1);
        end
      end
    end
  end

  // even halves carry the idle level when phase is clear
  assign sck_o      = busy_q ? (flags_q.cpol ^ odd ^ flags_q.cpha) : flags_q.cpol;
  assign mosi_oe_o  = !flags_q.offline && !(flags_q.half && flags_q.cap);
  assign pins_oe_o  = !flags_q.offline;
  assign busy_o     = busy_q;
  assign err_o      = err_q;
  assign rd_valid_o = rdv_q;

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_o[k] = (cs_act_q && mask_q[k]) ? flags_q.cs_pol : ~flags_q.cs_pol;
  end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_we_i,
  input logic           data_we_i,
  input logic           busy_o,
  input logic           err_o,
  input logic           rd_valid_o,
  input logic [NCS-1:0] cs_o
);
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !busy_o) |=> busy_o);

  // R9
  refuse_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_we_i || data_we_i) && busy_o) |=> err_o);

  // R9
  idle_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !err_o);

  // R6
  event_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $fell(busy_o));

  // R5
  cs_idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cfg_we_i && !data_we_i) |=> $stable(cs_o));
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.NCS(NCS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .data_we_i  (data_we_i),
  .busy_o     (busy_o),
  .err_o      (err_o),
  .rd_valid_o (rd_valid_o),
  .cs_o       (cs_o)
);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;
  localparam int NCS = 4;
  localparam int CFW = 21 + NCS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, data_we = 1'b0;
  logic [CFW-1:0] cfg = '0;
  logic [31:0] data = '0;
  logic busy, err, rd_valid, sck, mosi, mosi_oe, pins_oe;
  logic [31:0] rd_data;
  logic [NCS-1:0] cs;
  logic mosi_in, miso_in;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];

  // behavioural slave
  logic s_en = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_half = 1'b0, s_bit = 1'b0;
  logic [31:0] s_word = '0, s_cap = '0;
  int s_len = 0, s_n = 0;

  assign mosi_in = s_bit;
  assign miso_in = s_half ? ~s_bit : s_bit;

  always #4 clk = ~clk;

  spi_xfer_master #(.NCS(NCS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_i(cfg),
    .data_we_i(data_we), .data_i(data), .busy_o(busy), .err_o(err),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .sck_o(sck), .mosi_o(mosi),
    .mosi_oe_o(mosi_oe), .mosi_i(mosi_in), .miso_i(miso_in), .cs_o(cs),
    .pins_oe_o(pins_oe)
  );

  always @(sck) begin
    if (s_en) begin
      if ((sck != s_cpol) ^ s_cpha) s_cap = {s_cap[30:0], mosi};
      else begin
        if (s_n < s_len) s_bit = s_word[s_len-1-s_n];
        s_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare read events against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected event", rd_data, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R3/R6 read word", rd_data, e);
      end
    end
  end

  function automatic logic [CFW-1:0] mk(input bit off, input bit last, input bit cap,
      input bit cspol, input bit cpol, input bit cpha, input bit lsb, input bit half,
      input int len, input int d, input logic [NCS-1:0] mask);
    logic [CFW-1:0] w;
    w = '0;
    w[0] = off; w[1] = last; w[2] = cap; w[3] = cspol;
    w[4] = cpol; w[5] = cpha; w[6] = lsb; w[7] = half;
    w[12:8]  = 5'(len - 1);
    w[20:13] = 8'(d - 2);
    w[CFW-1:21] = mask;
    return w;
  endfunction

  task automatic write_cfg(input logic [CFW-1:0] w);
    @(negedge clk); cfg = w; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic xfer(input logic [CFW-1:0] w, input logic [31:0] d_word,
      input logic [31:0] sword, input bit same, input bit poke, input string req);
    int len, dv, cnt;
    bit lsb, cap, half;
    logic [31:0] exp_tx, exp_rx;
    len = int'(w[12:8]) + 1; dv = int'(w[20:13]) + 2;
    lsb = w[6]; cap = w[2]; half = w[7];
    exp_tx = '0; exp_rx = '0;
    for (int i = 0; i < len; i++) begin
      exp_tx = {exp_tx[30:0], lsb ? d_word[i] : d_word[31-i]};
      if (lsb) exp_rx[i] = sword[len-1-i];
      else     exp_rx = {exp_rx[30:0], sword[len-1-i]};
    end
    if (cap) exp_q.push_back(exp_rx);
    if (!same) write_cfg(w);
    s_cpol = w[4]; s_cpha = w[5]; s_half = half; s_word = sword; s_len = len;
    s_cap = '0; s_n = 0;
    if (!w[5]) begin s_bit = sword[len-1]; s_n = 1; end
    s_en = 1'b1;
    @(negedge clk);
    data = d_word; data_we = 1'b1;
    if (same) begin cfg = w; cfg_we = 1'b1; end
    @(negedge clk);
    data_we = 1'b0; cfg_we = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      if (poke && cnt == 3) begin
        cfg = mk(0, 1, 0, 0, 0, 0, 0, 0, 1, 2, '0); cfg_we = 1'b1;
        data = ~d_word; data_we = 1'b1;
      end
      @(negedge clk);
      if (poke && cnt == 3) begin
        cfg_we = 1'b0; data_we = 1'b0;
        chk(err == 1'b1, "R9 error pulse", 32'(err), 32'h1);
      end
    end
    chk(cnt == len * dv, {req, " duration (R2)"}, cnt, len * dv);
    if (!(half && cap)) chk(s_cap == exp_tx, {req, " MOSI bits (R3/R4)"}, s_cap, exp_tx);
    s_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_cs(input logic [NCS-1:0] e, input string req);
    chk(cs == e, req, 32'(cs), 32'(e));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: all flags clear
    chk(busy == 1'b0 && err == 1'b0 && rd_valid == 1'b0, "R1 reset outputs", {busy, err, rd_valid}, 0);
    chk_cs(4'b1111, "R5 reset cs inactive");
    chk(sck == 1'b0 && pins_oe && mosi_oe, "R4/R8 reset pins", {sck, pins_oe, mosi_oe}, 3'b011);

    // R3 opcode, MSB-first mode 0, slaves 1 and 2, not last
    xfer(mk(0, 0, 0, 0, 0, 0, 0, 0, 8, 125, 4'b0110), 32'h13 << 24, 32'h0, 0, 0, "R3 opcode");
    chk_cs(4'b1001, "R5 cs held between transfers");
    // R6 payload with end and capture
    xfer(mk(0, 1, 1, 0, 0, 0, 0, 0, 32, 4, 4'b0110), 32'hDEADBEEF, 32'hA5C30F96, 0, 0, "R3 payload");
    chk_cs(4'b1111, "R5 cs released after end");

    // R4 idle high clock, phase set, LSB-first, odd divisor, active-high cs
    xfer(mk(0, 0, 1, 1, 1, 1, 1, 0, 12, 3, 4'b0001), 32'h00000B3D, 32'h00000E71, 0, 0, "R4 mode3 lsb");
    chk_cs(4'b0001, "R5 active-high cs held");
    chk(sck == 1'b1, "R4 idle level high", 32'(sck), 32'h1);
    xfer(mk(0, 1, 1, 1, 0, 1, 0, 0, 5, 2, 4'b0001), 32'hB8000000, 32'h00000013, 0, 0, "R4 mode1 min div");
    chk_cs(4'b0000, "R5 active-high cs released");

    // R7 half duplex read
    write_cfg(mk(0, 1, 1, 0, 0, 0, 0, 1, 16, 4, 4'b1000));
    chk(mosi_oe == 1'b0, "R7 mosi released", 32'(mosi_oe), 32'h0);
    xfer(mk(0, 1, 1, 0, 0, 0, 0, 1, 16, 4, 4'b1000), 32'h0, 32'h00009C5A, 0, 0, "R7 half duplex");

    // R9 writes during a transfer are refused
    xfer(mk(0, 1, 0, 0, 0, 0, 0, 0, 16, 6, 4'b0010), 32'hC3A50000, 32'h0, 0, 1, "R9 poke");

    // R10 config and data in the same cycle
    write_cfg(mk(0, 1, 0, 0, 0, 0, 0, 0, 32, 8, 4'b0001));
    xfer(mk(0, 1, 1, 0, 0, 1, 1, 0, 7, 5, 4'b0100), 32'h00000055, 32'h0000003C, 1, 0, "R10 same cycle");

    // R2 largest divisor, single bit
    xfer(mk(0, 1, 0, 0, 0, 0, 0, 0, 1, 257, 4'b0001), 32'h80000000, 32'h0, 0, 0, "R2 max div");

    // R8 offline
    write_cfg(mk(1, 1, 0, 0, 0, 0, 0, 0, 8, 4, 4'b1111));
    chk(pins_oe == 1'b0 && mosi_oe == 1'b0, "R8 offline tri-state", {pins_oe, mosi_oe}, 0);
    write_cfg(mk(0, 1, 0, 0, 0, 0, 0, 0, 8, 4, 4'b1111));
    chk(pins_oe == 1'b1, "R8 back online", 32'(pins_oe), 32'h1);

    repeat (5) @(negedge clk);
    // R6 every expected event arrived, none without capture
    chk(exp_q.size() == 0, "R6 events pending", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule